// File: doc/BRIEF.md
# Next-Line Prefetch Trigger Controller

This block sits beside a direct-indexed cache and decides, one access at a time, whether the line after the one just referenced should be fetched ahead of demand. Each cycle the cache may present one reference with its line address and a hit or miss flag. The controller drives the address of the following line on a probe output. The cache answers combinationally with whether that line is already resident. When a trigger survives the filters, the next-line address is loaded into a single outstanding request slot. That slot is offered to memory with a valid/ready handshake.

Three trigger policies are selectable at run time. The first fires on every reference. The second fires on misses only. The third fires on misses and on the first use of a line that arrived by prefetch. For the third policy the controller holds one marker bit per cache index. A line filled by prefetch gets its marker set. A line filled on demand gets its marker cleared. The first hit on a marked line clears the marker and counts as a trigger. A fourth mode code switches prefetching off.

Top module: `pf_next_line_ctrl`

## Requirements
- R1: After reset no request is outstanding (`pf_valid` low) and every per-index marker is clear, so a hit in tagged mode before any fill produces no request.
- R2: In mode code 0 (always), every reference, hit or miss, loads a request for `acc_line + 1`, visible on `pf_valid`/`pf_line` one clock after the reference.
- R3: In mode code 1 (on miss), a reference with `acc_hit` = 1 produces no request and a reference with `acc_hit` = 0 requests `acc_line + 1`.
- R4: In mode code 2 (tagged), a fill with `fill_by_pf` = 1 marks index `fill_idx`. The first hit on a line at a marked index requests the next line, and a later hit on the same line does not.
- R5: In tagged mode a miss requests the next line. A fill with `fill_by_pf` = 0 leaves its index unmarked, so later hits there produce no request.
- R6: The next-line address wraps: a reference to the all-ones line address requests line 0.
- R7: When `probe_hit` is high in the cycle of a trigger, no request is loaded.
- R8: A trigger whose next-line address equals the request already outstanding in that cycle is suppressed, even when that request is accepted in the same cycle.
- R9: While `pf_valid` is high and `pf_ready` is low, `pf_line` holds and any new trigger is dropped. The request clears the cycle after `pf_ready` is seen high unless a new one loads.
- R10: Mode code 3 (off) produces no request for any reference.
- R11: The first hit on a marked index clears its marker even when the resulting request is suppressed, so a second hit does not request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Trigger policy: 0 always, 1 on miss, 2 tagged, 3 off |
| acc_valid | input | 1 | A cache reference is presented this cycle |
| acc_line | input | ADDR_W | Line address of the reference |
| acc_hit | input | 1 | The reference hit in the cache |
| probe_line | output | ADDR_W | Next-line address for the cache's residency lookup |
| probe_hit | input | 1 | The line on `probe_line` is already resident |
| fill_valid | input | 1 | A line is being written into the cache |
| fill_idx | input | IDX_W | Cache index being filled |
| fill_by_pf | input | 1 | The fill came from a prefetch (1) or a demand miss (0) |
| pf_valid | output | 1 | Outstanding prefetch request |
| pf_line | output | ADDR_W | Line address of the outstanding request |
| pf_ready | input | 1 | Memory accepts the outstanding request |

## Verification
The bench builds the controller with an 8-bit line address and 3-bit index. With that size the all-ones wrap case is a single reference away. Lines at different indices can be marked and consumed without disturbing each other. The memory side is held not ready over several cycles to expose the drop, hold and same-cycle duplicate cases. The defaults give a much wider address and about a thousand markers. They differ only in width, so the small build covers the same trigger and filter paths.

// File: rtl/pf_pkg.sv
package pf_pkg;
   typedef enum logic [1:0] {
      PF_ALWAYS  = 2'd0,
      PF_ON_MISS = 2'd1,
      PF_TAGGED  = 2'd2,
      PF_OFF     = 2'd3
   } pf_mode_e;
endpackage

// File: rtl/pf_mark_array.sv
module pf_mark_array #(
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic             fill_mark,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_mark
);
   localparam int NLINES = 1 << IDX_W;

   logic [NLINES-1:0] marks;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 16) else $error("IDX_W out of range");
   end

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n)
            marks[i] <= 1'b0;
         else if (fill_en && fill_idx == IDX_W'(i))
            marks[i] <= fill_mark;
         else if (clr_en && clr_idx == IDX_W'(i))
            marks[i] <= 1'b0;
      end
   end

   assign rd_mark = marks[rd_idx];

   // R11: a consumed marker is clear afterwards unless a fill rewrote it
   a_r11_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(fill_en && fill_idx == clr_idx)) |=> !marks[$past(clr_idx)]);

   // R4: a prefetch fill leaves its index marked
   a_r4_fill_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fill_mark) |=> marks[$past(fill_idx)]);
endmodule

// File: rtl/pf_trigger.sv
module pf_trigger
   import pf_pkg::*;
(
   input  pf_mode_e mode,
   input  logic     acc_valid,
   input  logic     acc_hit,
   input  logic     line_marked,
   output logic     trig,
   output logic     consume
);
   always_comb begin
      consume = acc_valid && acc_hit && line_marked;
      unique case (mode)
         PF_ALWAYS:  trig = acc_valid;
         PF_ON_MISS: trig = acc_valid && !acc_hit;
         PF_TAGGED:  trig = (acc_valid && !acc_hit) || consume;
         default:    trig = 1'b0;
      endcase
   end
endmodule

// File: rtl/pf_req_slot.sv
module pf_req_slot #(
   parameter int ADDR_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [ADDR_W-1:0] nxt_line,
   input  logic              resident,
   input  logic              ready,
   output logic              valid,
   output logic [ADDR_W-1:0] line
);
   logic slot_free, dup, load;

   initial begin
      assert (ADDR_W >= 2) else $error("ADDR_W too small");
   end

   always_comb begin
      slot_free = !valid || ready;
      dup       = valid && (line == nxt_line);
      load      = trig && !resident && !dup && slot_free;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         line  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         line  <= nxt_line;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

   // R9: a request that is not taken stays put
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(line)));

   // R8: a trigger matching the outstanding line never reloads it
   a_r8_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && trig && nxt_line == line) |=> !valid);
endmodule

// File: rtl/pf_next_line_ctrl.sv
module pf_next_line_ctrl
   import pf_pkg::*;
#(
   parameter int ADDR_W    = 26,
   parameter int IDX_W     = 10,
   parameter bit TAGGED_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_line,
   input  logic              acc_hit,
   output logic [ADDR_W-1:0] probe_line,
   input  logic              probe_hit,
   input  logic              fill_valid,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic              fill_by_pf,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_line,
   input  logic              pf_ready
);
   pf_mode_e   mode_e;
   logic       marked, trig, consume;
   logic [IDX_W-1:0] acc_idx;

   initial begin
      assert (IDX_W <= ADDR_W) else $error("IDX_W must not exceed ADDR_W");
   end

   assign mode_e     = pf_mode_e'(mode);
   assign acc_idx    = acc_line[IDX_W-1:0];
   assign probe_line = ADDR_W'(acc_line + 1'b1);

   if (TAGGED_EN) begin : g_marks
      pf_mark_array #(.IDX_W(IDX_W)) u_marks (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_en   (consume),
         .clr_idx  (acc_idx),
         .fill_en  (fill_valid),
         .fill_idx (fill_idx),
         .fill_mark(fill_by_pf),
         .rd_idx   (acc_idx),
         .rd_mark  (marked)
      );
   end else begin : g_nomarks
      assign marked = 1'b0;
   end

   pf_trigger u_trig (
      .mode       (mode_e),
      .acc_valid  (acc_valid),
      .acc_hit    (acc_hit),
      .line_marked(marked),
      .trig       (trig),
      .consume    (consume)
   );

   pf_req_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig),
      .nxt_line(probe_line),
      .resident(probe_hit),
      .ready   (pf_ready),
      .valid   (pf_valid),
      .line    (pf_line)
   );

   // R2 / R6: a free slot takes the wrapped next line of any reference
   a_r2_always_next: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && acc_valid && !probe_hit && !pf_valid)
      |=> (pf_valid && pf_line == ADDR_W'($past(acc_line) + 1'b1)));

   // R3: hits never request in miss-only mode
   a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && (!pf_valid || pf_ready)) && !(acc_valid && !acc_hit) |=> !pf_valid);

   // R7: resident next line is not requested
   a_r7_resident: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_hit && (!pf_valid || pf_ready)) |=> !pf_valid);

   // R10: off mode is silent
   a_r10_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && (!pf_valid || pf_ready)) |=> !pf_valid);
endmodule

// File: tb/pf_next_line_ctrl_tb.sv
module pf_next_line_ctrl_tb;
   localparam int AW = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          acc_valid = 1'b0;
   logic [AW-1:0] acc_line = '0;
   logic          acc_hit = 1'b0;
   logic [AW-1:0] probe_line;
   logic          probe_hit = 1'b0;
   logic          fill_valid = 1'b0;
   logic [IW-1:0] fill_idx = '0;
   logic          fill_by_pf = 1'b0;
   logic          pf_valid;
   logic [AW-1:0] pf_line;
   logic          pf_ready = 1'b1;

   typedef struct {
      logic          v;
      logic [AW-1:0] a;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   always #5 clk = ~clk;

   pf_next_line_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .acc_valid(acc_valid), .acc_line(acc_line), .acc_hit(acc_hit),
      .probe_line(probe_line), .probe_hit(probe_hit),
      .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_by_pf(fill_by_pf),
      .pf_valid(pf_valid), .pf_line(pf_line), .pf_ready(pf_ready)
   );

   // monitor: compare the outputs after each edge with the queued expectation
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (pf_valid !== e.v || (e.v && pf_line !== e.a)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b line=%02h, expected valid=%0b line=%02h",
                     e.tag, pf_valid, pf_line, e.v, e.a);
         end
      end
   end

   task automatic step(input logic [1:0] md, input logic av, input logic [AW-1:0] ln,
                       input logic hit, input logic ph, input logic fv,
                       input logic [IW-1:0] fi, input logic fp, input logic rdy,
                       input logic ev, input logic [AW-1:0] ea, input string tag);
      exp_t e;
      @(negedge clk);
      mode = md; acc_valid = av; acc_line = ln; acc_hit = hit; probe_hit = ph;
      fill_valid = fv; fill_idx = fi; fill_by_pf = fp; pf_ready = rdy;
      e.v = ev; e.a = ea; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset, and no marker set yet
      step(2'd0, 0, 8'h00, 0, 0, 0, 0, 0, 1, 0, 8'h00, "R1 idle after reset");
      step(2'd2, 1, 8'h05, 1, 0, 0, 0, 0, 1, 0, 8'h00, "R1 no marker after reset");
      // R2
      step(2'd0, 1, 8'h10, 1, 0, 0, 0, 0, 1, 1, 8'h11, "R2 hit requests next");
      step(2'd0, 1, 8'h20, 0, 0, 0, 0, 0, 1, 1, 8'h21, "R2 miss requests next");
      // R3
      step(2'd1, 1, 8'h30, 1, 0, 0, 0, 0, 1, 0, 8'h00, "R3 hit ignored");
      step(2'd1, 1, 8'h30, 0, 0, 0, 0, 0, 1, 1, 8'h31, "R3 miss requests");
      // R6
      step(2'd0, 1, 8'hFF, 1, 0, 0, 0, 0, 1, 1, 8'h00, "R6 wrap to zero");
      // R7
      step(2'd0, 1, 8'h40, 1, 1, 0, 0, 0, 1, 0, 8'h00, "R7 resident suppressed");
      // R10
      step(2'd3, 1, 8'h44, 0, 0, 0, 0, 0, 1, 0, 8'h00, "R10 off mode");
      // R4
      step(2'd2, 0, 8'h00, 0, 0, 1, 3'd2, 1, 1, 0, 8'h00, "R4 prefetch fill alone");
      step(2'd2, 1, 8'h52, 1, 0, 0, 0, 0, 1, 1, 8'h53, "R4 first use triggers");
      step(2'd2, 1, 8'h52, 1, 0, 0, 0, 0, 1, 0, 8'h00, "R4 second use quiet");
      // R5
      step(2'd2, 1, 8'h60, 0, 0, 0, 0, 0, 1, 1, 8'h61, "R5 tagged miss triggers");
      step(2'd2, 0, 8'h00, 0, 0, 1, 3'd0, 0, 1, 0, 8'h00, "R5 demand fill");
      step(2'd2, 1, 8'h60, 1, 0, 0, 0, 0, 1, 0, 8'h00, "R5 hit on demand line quiet");
      // R11
      step(2'd2, 0, 8'h00, 0, 0, 1, 3'd4, 1, 1, 0, 8'h00, "R11 prefetch fill");
      step(2'd2, 1, 8'h74, 1, 1, 0, 0, 0, 1, 0, 8'h00, "R11 first use suppressed");
      step(2'd2, 1, 8'h74, 1, 0, 0, 0, 0, 1, 0, 8'h00, "R11 marker already consumed");
      // R9
      step(2'd0, 1, 8'h80, 1, 0, 0, 0, 0, 0, 1, 8'h81, "R9 load with memory busy");
      step(2'd0, 1, 8'h90, 1, 0, 0, 0, 0, 0, 1, 8'h81, "R9 new trigger dropped");
      step(2'd0, 0, 8'h00, 0, 0, 0, 0, 0, 1, 0, 8'h00, "R9 cleared after accept");
      // R8
      step(2'd0, 1, 8'hA0, 1, 0, 0, 0, 0, 0, 1, 8'hA1, "R8 first request");
      step(2'd0, 1, 8'hA0, 1, 0, 0, 0, 0, 1, 0, 8'h00, "R8 duplicate suppressed");
      @(negedge clk);
      acc_valid = 1'b0; fill_valid = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule